// File: doc/BRIEF.md
# Pattern Fill and Verify Sequencer

This block runs a self-contained memory check over a region of 32-bit words. It runs seven passes. In each pass it first writes every word of the region in ascending address order with a value produced by that pass's data rule. It then reads every word back in the same order and compares each one against the value that was written. The first word that does not match ends the run. Its address, the value that was expected and the value actually read stay on the outputs until the next run starts.

Two coverage modes exist. Full mode tests the whole region. Sampled mode tests only short windows at each megabyte step inside the region. A periodic keep-alive pulse lets a system supervisor see that a long run is still making progress. The memory side is a plain synchronous port with one cycle of read latency and no wait states.

Top module: `fillscan_seq`

## Requirements
- R1: After reset, `done`, `fail`, `kick`, `mem_en` and `mem_we` are low and the three error fields are zero.
- R2: Passes run in a fixed order, and word index k of the current window gets one value per pass. Pass 0 writes 0x00000000. Pass 1 writes 0xFFFFFFFF. Pass 2 writes 0x55555555. Pass 3 writes 0xAAAAAAAA. Pass 4 writes 1 shifted left by (k mod 32). Pass 5 writes k. Pass 6 writes the bitwise inverse of k.
- R3: Within a pass, every word is written at ascending byte addresses (window base + 4·k) before any word is read. The reads then follow in the same ascending order. Read data is taken one cycle after the read request.
- R4: The first read that differs from its expected value stops the run. No further pass or window starts. `fail` rises and stays high until the next accepted `go`. `err_addr`, `err_exp` and `err_act` hold the failing word's address, the expected value and the value read.
- R5: `kick` pulses for one cycle with each write request and each read request whose word index is a multiple of 1024. It also pulses once after each pass that completes without a mismatch.
- R6: Full mode (`sampled`=0) tests floor(`byte_len`/4) words starting at `base_addr`. When that count is zero, the run ends with `done` and makes no memory access.
- R7: Sampled mode (`sampled`=1) visits windows of 0x800 bytes for each whole 1 MiB step i below `byte_len`. For each step it first tests the window at `base_addr` + i·0x100000, then the window at `base_addr` + i·0x100000 + 0xFF800. Each window receives all seven passes. With no whole step, the run ends with no access.
- R8: In sampled mode, a failure in one window stops the run, and later windows are never written.
- R9: The word index restarts at zero at the start of each window, so the walking-one and index-based values are relative to the window base.
- R10: `done` is high for exactly one cycle per run, at the end of the last pass or after the first failure. A `go` received while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; inputs below are captured with it |
| sampled | input | 1 | 0 = whole region, 1 = windows at each 1 MiB step |
| base_addr | input | AW | Byte address of the region start (word aligned) |
| byte_len | input | AW | Region size in bytes |
| mem_en | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| kick | output | 1 | Keep-alive pulse |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was found; held until the next start |
| err_addr | output | AW | Address of the first mismatch |
| err_exp | output | DW | Value expected at that address |
| err_act | output | DW | Value read at that address |

## Verification
A request appears on the memory port one cycle after the sequencer reaches the word. The read data is compared two edges after the read request. A mismatch raises `fail` at the following edge, and `done` follows one edge after that. On a clean run, `done` comes two edges after the final compare. The bench samples every output on the falling clock edge. It records the full request trace and checks it against a trace computed from the region geometry. It reads the error fields, the fail flag, the done count and the kick count only after `done` has been seen, plus a short margin, so no check depends on the exact cycle in which an internal step lands.

// File: rtl/fillscan_pkg.sv
package fillscan_pkg;

  typedef enum logic [2:0] {
    PS_ZERO  = 3'd0,
    PS_ONES  = 3'd1,
    PS_ALT01 = 3'd2,
    PS_ALT10 = 3'd3,
    PS_WALK  = 3'd4,
    PS_IDX   = 3'd5,
    PS_NIDX  = 3'd6
  } pass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WR,
    ST_RD,
    ST_DRAIN,
    ST_PEND,
    ST_FIN
  } st_e;

endpackage

// File: rtl/fillscan_valgen.sv
module fillscan_valgen
  import fillscan_pkg::*;
#(
  parameter int IW = 32,
  parameter int DW = 32
) (
  input  pass_e          pass,
  input  logic [IW-1:0]  idx,
  output logic [DW-1:0]  value
);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] idx_word;

  generate
    if (IW >= DW) begin : g_trunc
      assign idx_word = idx[DW-1:0];
    end else begin : g_extend
      assign idx_word = {{(DW-IW){1'b0}}, idx};
    end
  endgenerate

  always_comb begin
    case (pass)
      PS_ZERO:  value = '0;
      PS_ONES:  value = '1;
      PS_ALT01: value = {(DW/2){2'b01}};
      PS_ALT10: value = {(DW/2){2'b10}};
      PS_WALK:  value = DW'(1) << idx[SW-1:0];
      PS_IDX:   value = idx_word;
      PS_NIDX:  value = ~idx_word;
      default:  value = '0;
    endcase
  end
endmodule

// File: rtl/fillscan_window.sv
module fillscan_window #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int STEP_LG2  = 20,
  parameter int WIN_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          sampled,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] len_in,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_words,
  output logic          win_empty,
  output logic          win_last
);
  localparam int WB = $clog2(DW/8);
  localparam logic [AW-1:0] WIN_WORDS = AW'(WIN_BYTES / (DW/8));
  localparam logic [AW-1:0] HI_OFS    = AW'((64'd1 << STEP_LG2) - 64'(WIN_BYTES));

  logic          samp_q;
  logic          half_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] full_words_q;
  logic [AW-1:0] nsteps_q;
  logic [AW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q       <= 1'b0;
      half_q       <= 1'b0;
      base_q       <= '0;
      full_words_q <= '0;
      nsteps_q     <= '0;
      step_q       <= '0;
    end else if (load) begin
      samp_q       <= sampled;
      half_q       <= 1'b0;
      base_q       <= base_in;
      full_words_q <= len_in >> WB;
      nsteps_q     <= len_in >> STEP_LG2;
      step_q       <= '0;
    end else if (adv) begin
      if (half_q) begin
        half_q <= 1'b0;
        step_q <= step_q + 1'b1;
      end else begin
        half_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (samp_q) begin
      win_base  = base_q + (step_q << STEP_LG2) + (half_q ? HI_OFS : '0);
      win_words = WIN_WORDS;
      win_empty = (nsteps_q == '0);
      win_last  = half_q && (step_q == nsteps_q - 1'b1);
    end else begin
      win_base  = base_q;
      win_words = full_words_q;
      win_empty = (full_words_q == '0);
      win_last  = 1'b1;
    end
  end

  // R7: a sampled run never walks past its last whole megabyte step
  a_r7_step_in_range: assert property (@(posedge clk) disable iff (rst)
    (samp_q && !win_empty) |-> (step_q < nsteps_q));

  // R8: once the final window is reached no further advance is requested
  a_r8_no_adv_past_last: assert property (@(posedge clk) disable iff (rst)
    (win_last && !load) |-> !adv);
endmodule

// File: rtl/fillscan_cmp.sv
module fillscan_cmp #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_exp,
  input  logic          issue_last,
  input  logic          flush,
  input  logic [DW-1:0] rdata,
  output logic          mism,
  output logic          last_ok,
  output logic [AW-1:0] bad_addr,
  output logic [DW-1:0] bad_exp,
  output logic [DW-1:0] bad_act
);
  logic          t1v, t2v;
  logic          t1l, t2l;
  logic [AW-1:0] t1a, t2a;
  logic [DW-1:0] t1e, t2e;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      t1v <= 1'b0;
      t2v <= 1'b0;
    end else begin
      t1v <= issue;
      t2v <= t1v;
    end
  end

  always_ff @(posedge clk) begin
    t1a <= issue_addr;
    t1e <= issue_exp;
    t1l <= issue_last;
    t2a <= t1a;
    t2e <= t1e;
    t2l <= t1l;
  end

  assign mism     = t2v && (rdata != t2e);
  assign last_ok  = t2v && t2l && !mism;
  assign bad_addr = t2a;
  assign bad_exp  = t2e;
  assign bad_act  = rdata;

  // R3: two reads in flight always belong to consecutive ascending words
  a_r3_reads_ascend: assert property (@(posedge clk) disable iff (rst)
    (t1v && t2v) |-> (t1a == t2a + AW'(DW/8)));
endmodule

// File: rtl/fillscan_seq.sv
module fillscan_seq
  import fillscan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int STEP_LG2  = 20,
  parameter int WIN_BYTES = 2048,
  parameter int KICK_LG2  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          sampled,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] byte_len,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          kick,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_act
);
  localparam int WB = $clog2(DW/8);

  st_e           state;
  pass_e         pass;
  logic [AW-1:0] idx;

  logic [AW-1:0] win_base, win_words;
  logic          win_empty, win_last;
  logic [DW-1:0] cur_val;
  logic [AW-1:0] cur_addr;
  logic          at_last, kick_hit;
  logic          load, adv, issue;
  logic          mism, last_ok;
  logic [AW-1:0] bad_addr;
  logic [DW-1:0] bad_exp, bad_act;

  assign load     = (state == ST_IDLE) && go;
  assign adv      = (state == ST_PEND) && (pass == PS_NIDX) && !win_last;
  assign issue    = (state == ST_RD) && !mism;
  assign cur_addr = win_base + (idx << WB);
  assign at_last  = (idx == win_words - 1'b1);
  assign kick_hit = (idx[KICK_LG2-1:0] == '0);

  fillscan_window #(
    .AW(AW), .DW(DW), .STEP_LG2(STEP_LG2), .WIN_BYTES(WIN_BYTES)
  ) u_win (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .sampled(sampled),
    .base_in(base_addr), .len_in(byte_len),
    .win_base(win_base), .win_words(win_words),
    .win_empty(win_empty), .win_last(win_last)
  );

  fillscan_valgen #(.IW(AW), .DW(DW)) u_val (
    .pass(pass), .idx(idx), .value(cur_val)
  );

  fillscan_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .issue(issue), .issue_addr(cur_addr),
    .issue_exp(cur_val), .issue_last(at_last), .flush(mism),
    .rdata(mem_rdata), .mism(mism), .last_ok(last_ok),
    .bad_addr(bad_addr), .bad_exp(bad_exp), .bad_act(bad_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pass      <= PS_ZERO;
      idx       <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      kick      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      err_addr  <= '0;
      err_exp   <= '0;
      err_act   <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      kick   <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            fail     <= 1'b0;
            err_addr <= '0;
            err_exp  <= '0;
            err_act  <= '0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          idx   <= '0;
          pass  <= PS_ZERO;
          state <= win_empty ? ST_FIN : ST_WR;
        end
        ST_WR: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_addr;
          mem_wdata <= cur_val;
          kick      <= kick_hit;
          if (at_last) begin
            idx   <= '0;
            state <= ST_RD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RD: begin
          if (mism) begin
            fail     <= 1'b1;
            err_addr <= bad_addr;
            err_exp  <= bad_exp;
            err_act  <= bad_act;
            state    <= ST_FIN;
          end else begin
            mem_en   <= 1'b1;
            mem_addr <= cur_addr;
            kick     <= kick_hit;
            if (at_last) begin
              idx   <= '0;
              state <= ST_DRAIN;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (mism) begin
            fail     <= 1'b1;
            err_addr <= bad_addr;
            err_exp  <= bad_exp;
            err_act  <= bad_act;
            state    <= ST_FIN;
          end else if (last_ok) begin
            state <= ST_PEND;
          end
        end
        ST_PEND: begin
          kick <= 1'b1;
          if (pass == PS_NIDX) begin
            state <= win_last ? ST_FIN : ST_SETUP;
          end else begin
            pass  <= pass_e'(pass + 3'd1);
            state <= ST_WR;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: the end-of-run pulse never lasts two cycles
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: a detected mismatch is followed at once by the end of the run
  a_r4_fail_ends_run: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |=> done);

  // R4: the failure flag is only cleared by a new start
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail && !go) |=> fail);

  // R3: no write request is ever issued without a request strobe
  a_r3_we_with_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  // R10: the memory port is quiet while the block waits for a start
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !go) |=> !mem_en);
endmodule

// File: tb/sim_fillscan_seq.sv
module sim_fillscan_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        go, sampled;
  logic [31:0] base_addr, byte_len;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        kick, done, fail;
  logic [31:0] err_addr, err_exp, err_act;

  always #4 clk = ~clk;

  fillscan_seq u0 (
    .clk(clk), .rst(rst), .go(go), .sampled(sampled),
    .base_addr(base_addr), .byte_len(byte_len),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .kick(kick), .done(done), .fail(fail),
    .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] a;
    logic [31:0] d;
  } acc_t;

  acc_t        acc_q[$];
  logic [31:0] mem [logic [31:0]];
  bit          sa_on, cpl_on;
  logic [31:0] sa_addr, sa_and, sa_or, cpl_src, cpl_dst;
  int          n_chk = 0, n_fail = 0, n_kick = 0, n_done = 0;

  always @(posedge clk) begin
    logic [31:0] rv;
    if (mem_en) begin
      acc_q.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 32'h0});
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (cpl_on && mem_addr == cpl_src) mem[cpl_dst] = mem_wdata;
      end else begin
        rv = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (sa_on && mem_addr == sa_addr) rv = (rv & ~sa_and) | sa_or;
        mem_rdata <= rv;
      end
    end
  end

  always @(negedge clk) begin
    if (kick) n_kick++;
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expval(input int p, input int k);
    case (p)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'd1 << (k % 32);
      5: return 32'(k);
      default: return ~32'(k);
    endcase
  endfunction

  // compare the recorded request trace with one computed from the geometry
  task automatic check_trace(input logic [31:0] st, input logic [31:0] ln,
                             input bit sm, input string what);
    int nwin, words, pos, bad;
    logic [31:0] wb;
    acc_t e;
    nwin  = sm ? 2 * int'(ln >> 20) : ((ln >> 2) != 0 ? 1 : 0);
    words = sm ? 512 : int'(ln >> 2);
    pos = 0; bad = 0;
    for (int w = 0; w < nwin; w++) begin
      wb = sm ? st + (32'(w / 2) << 20) + ((w % 2) ? 32'h000F_F800 : 32'h0) : st;
      for (int p = 0; p < 7; p++) begin
        for (int k = 0; k < words; k++) begin
          e = {1'b1, wb + 32'(4 * k), expval(p, k)};
          if (pos >= acc_q.size() || acc_q[pos] != e) bad++;
          pos++;
        end
        for (int k = 0; k < words; k++) begin
          e = {1'b0, wb + 32'(4 * k), 32'h0};
          if (pos >= acc_q.size() || acc_q[pos] != e) bad++;
          pos++;
        end
      end
    end
    if (pos != acc_q.size()) bad++;
    chk(bad == 0, "R2 R3", what, 64'(bad), 64'd0);
  endtask

  function automatic int n_writes();
    int c = 0;
    foreach (acc_q[i]) if (acc_q[i].we) c++;
    return c;
  endfunction

  task automatic run(input logic [31:0] st, input logic [31:0] ln,
                     input bit sm, input int poke_at);
    int cyc;
    acc_q.delete();
    mem.delete();
    n_kick = 0;
    n_done = 0;
    @(negedge clk);
    base_addr = st; byte_len = ln; sampled = sm; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    cyc = 0;
    while (n_done == 0) begin
      @(negedge clk);
      cyc++;
      if (poke_at > 0 && cyc == poke_at) begin
        base_addr = 32'h0000_5000; byte_len = 32'h0; sampled = 1'b1; go = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic no_faults();
    sa_on = 1'b0; cpl_on = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; go = 1'b0; sampled = 1'b0; base_addr = '0; byte_len = '0;
    no_faults();
    sa_addr = '0; sa_and = '0; sa_or = '0; cpl_src = '0; cpl_dst = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !fail && !kick && !mem_en && !mem_we, "R1", "control outputs",
        64'({done, fail, kick, mem_en, mem_we}), 64'd0);
    chk(err_addr == 0 && err_exp == 0 && err_act == 0, "R1", "error fields",
        {err_addr, err_exp}, 64'd0);

    // full mode, 16 words
    run(32'h100, 32'h40, 1'b0, 0);
    check_trace(32'h100, 32'h40, 1'b0, "full 16 words");
    chk(n_kick == 21, "R5", "kicks 16 words", 64'(n_kick), 64'd21);
    chk(n_done == 1 && !fail, "R10", "single done clean", 64'(n_done), 64'd1);

    // full mode, 2048 words: two kick points per phase
    run(32'h4000, 32'h2000, 1'b0, 0);
    check_trace(32'h4000, 32'h2000, 1'b0, "full 2048 words");
    chk(n_kick == 35, "R5", "kicks 2048 words", 64'(n_kick), 64'd35);

    // R6 zero-word full region
    run(32'h100, 32'h3, 1'b0, 0);
    chk(acc_q.size() == 0 && n_done == 1 && !fail, "R6", "empty full region",
        64'(acc_q.size()), 64'd0);

    // R7 sampled mode, two megabyte steps, size with a tail
    run(32'h1000, 32'h0020_0123, 1'b1, 0);
    check_trace(32'h1000, 32'h0020_0123, 1'b1, "R7 sampled four windows");
    chk(n_kick == 84, "R5", "kicks sampled", 64'(n_kick), 64'd84);

    // R7 sampled mode below one step
    run(32'h1000, 32'h000F_FFFF, 1'b1, 0);
    chk(acc_q.size() == 0 && n_done == 1 && !fail, "R7", "no whole step",
        64'(acc_q.size()), 64'd0);

    // R4 stuck-at-0 on bit 7 of word 5: fails in pass 1
    sa_on = 1'b1; sa_addr = 32'h114; sa_and = 32'h80; sa_or = 32'h0;
    run(32'h100, 32'h40, 1'b0, 0);
    chk(fail == 1'b1, "R4", "fail flag", 64'(fail), 64'd1);
    chk(err_addr == 32'h114, "R4", "err_addr", 64'(err_addr), 64'h114);
    chk(err_exp == 32'hFFFF_FFFF && err_act == 32'hFFFF_FF7F, "R4", "exp/act",
        {err_exp, err_act}, {32'hFFFF_FFFF, 32'hFFFF_FF7F});
    chk(n_writes() == 32, "R4", "no later pass", 64'(n_writes()), 64'd32);
    chk(n_done == 1, "R10", "single done on fail", 64'(n_done), 64'd1);
    no_faults();

    // R4 fail cleared by new start; R10 go while busy ignored
    run(32'h100, 32'h40, 1'b0, 20);
    chk(fail == 1'b0, "R4", "fail cleared by start", 64'(fail), 64'd0);
    check_trace(32'h100, 32'h40, 1'b0, "R10 busy go ignored");
    chk(n_done == 1, "R10", "single done after poke", 64'(n_done), 64'd1);

    // R2 coupling word 8 -> word 3: walking-one pass fails
    cpl_on = 1'b1; cpl_src = 32'h120; cpl_dst = 32'h10C;
    run(32'h100, 32'h40, 1'b0, 0);
    chk(fail && err_addr == 32'h10C, "R2", "walk fail addr", 64'(err_addr), 64'h10C);
    chk(err_exp == 32'h8 && err_act == 32'h100, "R2", "walk exp/act",
        {err_exp, err_act}, {32'h8, 32'h100});
    chk(n_writes() == 80, "R4", "stop after pass 4", 64'(n_writes()), 64'd80);
    no_faults();

    // R2 coupling 34 -> 2: walking one aliases, index pass fails
    cpl_on = 1'b1; cpl_src = 32'h2088; cpl_dst = 32'h2008;
    run(32'h2000, 32'h100, 1'b0, 0);
    chk(fail && err_exp == 32'h2 && err_act == 32'h22, "R2", "index pass exp/act",
        {err_exp, err_act}, {32'h2, 32'h22});
    chk(n_writes() == 384, "R4", "stop after pass 5", 64'(n_writes()), 64'd384);
    no_faults();

    // R8 stuck-at-1 in third window, pass 0
    sa_on = 1'b1; sa_addr = 32'h0010_1008; sa_and = 32'h0; sa_or = 32'h1;
    run(32'h1000, 32'h0020_0000, 1'b1, 0);
    chk(fail && err_addr == 32'h0010_1008 && err_act == 32'h1 && err_exp == 32'h0,
        "R8", "window 2 error", {err_addr, err_act}, {32'h0010_1008, 32'h1});
    chk(n_writes() == 7680, "R8", "later windows untouched", 64'(n_writes()), 64'd7680);
    no_faults();

    // R9 coupling inside fourth window: index relative to window base
    cpl_on = 1'b1; cpl_src = 32'h0020_0814; cpl_dst = 32'h0020_0804;
    run(32'h1000, 32'h0020_0000, 1'b1, 0);
    chk(fail && err_addr == 32'h0020_0804, "R9", "window 3 addr",
        64'(err_addr), 64'h0020_0804);
    chk(err_exp == 32'h2 && err_act == 32'h20, "R9", "relative walk values",
        {err_exp, err_act}, {32'h2, 32'h20});
    chk(n_writes() == 13312, "R8", "stop in window 3", 64'(n_writes()), 64'd13312);
    no_faults();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule